// File: doc/BRIEF.md
# Dual-Pointer Modulo Address Selector

This block computes the post-increment value of two data-memory address pointers in one step: one pointer that addresses X memory and one that addresses Y memory. Each pointer is added to its own increment. A pointer can run as a circular buffer bounded by a shared start/end address pair. In that case an increment that carries the pointer beyond the end address brings it back to the start address, and a one-cycle wrap flag goes high.

Two enable bits pick the family that wraps: one for X and one for Y. The pointer families cannot both be circular. When both bits are set, Y keeps circular addressing and X falls back to plain addition. Circular addressing is also tied to the transfer class. It applies only to dual X/Y parallel transfers, so a single data transfer always updates linearly. The caller chooses which physical pointer register feeds each input and writes the result back. Each updated pointer appears on the outputs one clock after the update request.

Top module: `dual_ptr_modsel`

## Requirements
- R1: While rst_ni is low, x_ptr_o and y_ptr_o are 0 and x_wrap_o and y_wrap_o are 0.
- R2: A pointer whose update input (x_upd_i / y_upd_i) is 0 at a clock edge keeps its output value, and its wrap flag is 0 after that edge.
- R3: A pointer that is updated while its family is not circular becomes (ptr + inc) mod 2^AW, and its wrap flag is 0.
- R4: With dual_xfer_i=1, x_mod_en_i=1 and y_mod_en_i=0, an X update whose full-width sum x_ptr_i+x_inc_i is greater than mod_end_i gives x_ptr_o = mod_start_i and x_wrap_o = 1. Otherwise x_ptr_o is the sum and x_wrap_o is 0.
- R5: With dual_xfer_i=1 and y_mod_en_i=1, a Y update applies the same wrap rule to y_ptr_i+y_inc_i, driving y_ptr_o and y_wrap_o.
- R6: When both x_mod_en_i and y_mod_en_i are 1, only Y is circular, X updates linearly, and the two wrap flags are never high together.
- R7: With dual_xfer_i=0 (single transfer), both pointers update linearly and neither wrap flag rises, whatever the enable bits hold.
- R8: A wrap flag stays high for one cycle only. If the next update does not wrap, the flag is 0 after that update.
- R9: The updated pointer and its wrap flag appear on the outputs at the first rising clock edge after the update request is presented.
- R10: In circular mode a sum that carries out of AW bits counts as beyond the end address and wraps to mod_start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_upd_i | input | 1 | Update the X pointer at this edge |
| y_upd_i | input | 1 | Update the Y pointer at this edge |
| dual_xfer_i | input | 1 | 1 = dual X/Y parallel transfer, 0 = single transfer |
| x_mod_en_i | input | 1 | Circular addressing requested for X |
| y_mod_en_i | input | 1 | Circular addressing requested for Y (takes priority) |
| x_ptr_i | input | AW | Current X pointer |
| y_ptr_i | input | AW | Current Y pointer |
| x_inc_i | input | AW | X increment |
| y_inc_i | input | AW | Y increment |
| mod_start_i | input | AW | Circular buffer start address |
| mod_end_i | input | AW | Circular buffer end address |
| x_ptr_o | output | AW | Updated X pointer |
| y_ptr_o | output | AW | Updated Y pointer |
| x_wrap_o | output | 1 | X wrapped at the last update |
| y_wrap_o | output | 1 | Y wrapped at the last update |

## Verification
Directed cases cover each combination of the two enable bits with dual and with single transfers, using sums on both sides of the end address. A wrong priority between families, or circular addressing leaking into single transfers, therefore shows up as a wrong pointer value. One case places the pointer so that the sum carries out of the address width. There, a circular update and a linear update give different results, which separates a truncated comparison from a full-width one. A long pseudo-random run then mixes update enables, transfer types and pointers near the region edges. A behavioural model checks every clock and catches wrong holding and flags that last more than one cycle.

// File: rtl/modsel_pkg.sv
package modsel_pkg;
  localparam int unsigned NUM_LANES = 2;
  localparam int unsigned LANE_X = 0;
  localparam int unsigned LANE_Y = 1;

  typedef enum logic {
    ADDR_LINEAR   = 1'b0,
    ADDR_CIRCULAR = 1'b1
  } addr_mode_e;
endpackage

// File: rtl/modsel_mode_dec.sv
module modsel_mode_dec
  import modsel_pkg::*;
(
  input  logic       dual_xfer_i,
  input  logic       x_mod_en_i,
  input  logic       y_mod_en_i,
  output addr_mode_e x_mode_o,
  output addr_mode_e y_mode_o
);
  // Y wins when both enables are set; single transfers never wrap
  always_comb begin
    x_mode_o = ADDR_LINEAR;
    y_mode_o = ADDR_LINEAR;
    if (dual_xfer_i) begin
      if (y_mod_en_i)      y_mode_o = ADDR_CIRCULAR;
      else if (x_mod_en_i) x_mode_o = ADDR_CIRCULAR;
    end
  end
endmodule

// File: rtl/modsel_lane.sv
module modsel_lane
  import modsel_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  addr_mode_e    mode_i,
  input  logic [AW-1:0] ptr_i,
  input  logic [AW-1:0] inc_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  output logic [AW-1:0] nxt_o,
  output logic          wrap_o
);
  localparam int unsigned SW = AW + 1;

  logic [SW-1:0] sum;
  logic          beyond_end;

  // full-width sum so a carry counts as past the end
  assign sum        = {1'b0, ptr_i} + {1'b0, inc_i};
  assign beyond_end = sum > {1'b0, end_i};
  assign wrap_o     = (mode_i == ADDR_CIRCULAR) && beyond_end;
  assign nxt_o      = wrap_o ? start_i : sum[AW-1:0];
endmodule

// File: rtl/dual_ptr_modsel.sv
module dual_ptr_modsel
  import modsel_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          x_upd_i,
  input  logic          y_upd_i,
  input  logic          dual_xfer_i,
  input  logic          x_mod_en_i,
  input  logic          y_mod_en_i,
  input  logic [AW-1:0] x_ptr_i,
  input  logic [AW-1:0] y_ptr_i,
  input  logic [AW-1:0] x_inc_i,
  input  logic [AW-1:0] y_inc_i,
  input  logic [AW-1:0] mod_start_i,
  input  logic [AW-1:0] mod_end_i,
  output logic [AW-1:0] x_ptr_o,
  output logic [AW-1:0] y_ptr_o,
  output logic          x_wrap_o,
  output logic          y_wrap_o
);
  addr_mode_e    lane_mode [NUM_LANES];
  logic          lane_upd  [NUM_LANES];
  logic [AW-1:0] lane_ptr  [NUM_LANES];
  logic [AW-1:0] lane_inc  [NUM_LANES];
  logic [AW-1:0] lane_q    [NUM_LANES];
  logic          lane_wq   [NUM_LANES];

  modsel_mode_dec u_mode_dec (
    .dual_xfer_i (dual_xfer_i),
    .x_mod_en_i  (x_mod_en_i),
    .y_mod_en_i  (y_mod_en_i),
    .x_mode_o    (lane_mode[LANE_X]),
    .y_mode_o    (lane_mode[LANE_Y])
  );

  assign lane_upd[LANE_X] = x_upd_i;
  assign lane_upd[LANE_Y] = y_upd_i;
  assign lane_ptr[LANE_X] = x_ptr_i;
  assign lane_ptr[LANE_Y] = y_ptr_i;
  assign lane_inc[LANE_X] = x_inc_i;
  assign lane_inc[LANE_Y] = y_inc_i;

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [AW-1:0] nxt;
    logic          wrap;
    logic [AW-1:0] ptr_q;
    logic          wrap_q;

    modsel_lane #(.AW(AW)) u_lane (
      .mode_i  (lane_mode[g]),
      .ptr_i   (lane_ptr[g]),
      .inc_i   (lane_inc[g]),
      .start_i (mod_start_i),
      .end_i   (mod_end_i),
      .nxt_o   (nxt),
      .wrap_o  (wrap)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ptr_q  <= '0;
        wrap_q <= 1'b0;
      end else begin
        wrap_q <= lane_upd[g] & wrap;
        if (lane_upd[g]) ptr_q <= nxt;
      end
    end

    assign lane_q[g]  = ptr_q;
    assign lane_wq[g] = wrap_q;
  end

  assign x_ptr_o  = lane_q[LANE_X];
  assign y_ptr_o  = lane_q[LANE_Y];
  assign x_wrap_o = lane_wq[LANE_X];
  assign y_wrap_o = lane_wq[LANE_Y];
endmodule

// File: rtl/dual_ptr_modsel_chk.sv
module dual_ptr_modsel_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          x_upd_i,
  input logic          y_upd_i,
  input logic          dual_xfer_i,
  input logic          x_mod_en_i,
  input logic          y_mod_en_i,
  input logic [AW-1:0] x_ptr_i,
  input logic [AW-1:0] y_ptr_i,
  input logic [AW-1:0] x_inc_i,
  input logic [AW-1:0] y_inc_i,
  input logic [AW-1:0] mod_start_i,
  input logic [AW-1:0] mod_end_i,
  input logic [AW-1:0] x_ptr_o,
  input logic [AW-1:0] y_ptr_o,
  input logic          x_wrap_o,
  input logic          y_wrap_o
);
  // R2
  x_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !x_upd_i |=> $stable(x_ptr_o) && !x_wrap_o);

  // R2
  y_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !y_upd_i |=> $stable(y_ptr_o) && !y_wrap_o);

  // R7
  single_lin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_upd_i && !dual_xfer_i) |=> x_ptr_o == $past(x_ptr_i + x_inc_i) && !x_wrap_o);

  // R6
  x_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (x_mod_en_i && y_mod_en_i) |=> !x_wrap_o);

  // R6
  one_family_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(x_wrap_o && y_wrap_o));

  // R4
  x_wrap_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(x_wrap_o) |-> x_ptr_o == $past(mod_start_i));

  // R5
  y_wrap_val_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_upd_i && dual_xfer_i && y_mod_en_i && ({1'b0, y_ptr_i} + {1'b0, y_inc_i} > {1'b0, mod_end_i})
    |=> y_wrap_o && y_ptr_o == $past(mod_start_i));
endmodule

bind dual_ptr_modsel dual_ptr_modsel_chk #(.AW(AW)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .x_upd_i     (x_upd_i),
  .y_upd_i     (y_upd_i),
  .dual_xfer_i (dual_xfer_i),
  .x_mod_en_i  (x_mod_en_i),
  .y_mod_en_i  (y_mod_en_i),
  .x_ptr_i     (x_ptr_i),
  .y_ptr_i     (y_ptr_i),
  .x_inc_i     (x_inc_i),
  .y_inc_i     (y_inc_i),
  .mod_start_i (mod_start_i),
  .mod_end_i   (mod_end_i),
  .x_ptr_o     (x_ptr_o),
  .y_ptr_o     (y_ptr_o),
  .x_wrap_o    (x_wrap_o),
  .y_wrap_o    (y_wrap_o)
);

// File: tb/dual_ptr_modsel_tb_top.sv
`timescale 1ns/1ps
module dual_ptr_modsel_tb_top;
  localparam int unsigned AW = 16;
  localparam int MASK = (1 << AW) - 1;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          x_upd_i = 1'b0, y_upd_i = 1'b0, dual_xfer_i = 1'b0;
  logic          x_mod_en_i = 1'b0, y_mod_en_i = 1'b0;
  logic [AW-1:0] x_ptr_i = '0, y_ptr_i = '0, x_inc_i = '0, y_inc_i = '0;
  logic [AW-1:0] mod_start_i = '0, mod_end_i = '0;
  logic [AW-1:0] x_ptr_o, y_ptr_o;
  logic          x_wrap_o, y_wrap_o;

  int checks = 0;
  int errors = 0;
  int exp_x = 0, exp_y = 0;
  bit exp_xw = 0, exp_yw = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dual_ptr_modsel #(.AW(AW)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .x_upd_i(x_upd_i), .y_upd_i(y_upd_i), .dual_xfer_i(dual_xfer_i),
    .x_mod_en_i(x_mod_en_i), .y_mod_en_i(y_mod_en_i),
    .x_ptr_i(x_ptr_i), .y_ptr_i(y_ptr_i), .x_inc_i(x_inc_i), .y_inc_i(y_inc_i),
    .mod_start_i(mod_start_i), .mod_end_i(mod_end_i),
    .x_ptr_o(x_ptr_o), .y_ptr_o(y_ptr_o), .x_wrap_o(x_wrap_o), .y_wrap_o(y_wrap_o)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference: one lane update
  task automatic model(bit upd, bit circ, int p, int inc, ref int st, ref bit w);
    int s;
    s = p + inc;
    w = 0;
    if (!upd) return;
    if (circ && s > int'(mod_end_i)) begin
      st = int'(mod_start_i);
      w  = 1;
    end else begin
      st = s & MASK;
    end
  endtask

  function automatic string lane_tag(bit is_x, bit upd, int p, int inc);
    if (!upd) return "R2";
    if (!dual_xfer_i) return "R7";
    if (is_x && x_mod_en_i && y_mod_en_i) return "R6";
    if (is_x ? (x_mod_en_i && !y_mod_en_i) : y_mod_en_i) begin
      if (p + inc > MASK) return "R10";
      return is_x ? "R4" : "R5";
    end
    return "R3";
  endfunction

  task automatic step(bit ux, bit uy, bit dl, bit mx, bit my,
                      int xp, int yp, int xi, int yi, string force_tag);
    string tx, ty;
    bit xc, yc;
    x_upd_i = ux; y_upd_i = uy; dual_xfer_i = dl;
    x_mod_en_i = mx; y_mod_en_i = my;
    x_ptr_i = xp[AW-1:0]; y_ptr_i = yp[AW-1:0];
    x_inc_i = xi[AW-1:0]; y_inc_i = yi[AW-1:0];
    xc = dl && mx && !my;
    yc = dl && my;
    model(ux, xc, int'(x_ptr_i), int'(x_inc_i), exp_x, exp_xw);
    model(uy, yc, int'(y_ptr_i), int'(y_inc_i), exp_y, exp_yw);
    tx = (force_tag != "") ? force_tag : lane_tag(1, ux, int'(x_ptr_i), int'(x_inc_i));
    ty = (force_tag != "") ? force_tag : lane_tag(0, uy, int'(y_ptr_i), int'(y_inc_i));
    @(negedge clk_i);
    check(tx, "x_ptr_o", int'(x_ptr_o), exp_x);
    check(tx, "x_wrap_o", int'(x_wrap_o), int'(exp_xw));
    check(ty, "y_ptr_o", int'(y_ptr_o), exp_y);
    check(ty, "y_wrap_o", int'(y_wrap_o), int'(exp_yw));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mod_start_i = 16'h0100;
    mod_end_i   = 16'h013F;
    repeat (3) @(negedge clk_i);
    // R1: reset values
    check("R1", "x_ptr_o", int'(x_ptr_o), 0);
    check("R1", "y_ptr_o", int'(y_ptr_o), 0);
    check("R1", "x_wrap_o", int'(x_wrap_o), 0);
    check("R1", "y_wrap_o", int'(y_wrap_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9: one-edge latency, linear
    step(1, 1, 1, 0, 0, 'h0010, 'h0020, 2, 3, "R9");
    // R3: plain add with carry dropped
    step(1, 1, 1, 0, 0, 'hFFFF, 'hFFFE, 3, 4, "R3");
    // R4: X circular, in range then beyond end
    step(1, 1, 1, 1, 0, 'h0130, 'h0130, 'h0F, 'h20, "R4");
    step(1, 0, 1, 1, 0, 'h013C, 0, 'h08, 0, "R4");
    // R8: next update no wrap, flag drops
    step(1, 0, 1, 1, 0, 'h0100, 0, 1, 0, "R8");
    // R5: Y circular
    step(0, 1, 1, 0, 1, 0, 'h013E, 0, 4, "R5");
    step(0, 1, 1, 0, 1, 0, 'h0101, 0, 4, "R8");
    // R6: both enables, X linear past end, Y wraps
    step(1, 1, 1, 1, 1, 'h013E, 'h013E, 4, 4, "R6");
    // R7: single transfer ignores enables
    step(1, 1, 0, 1, 0, 'h013E, 'h013E, 4, 4, "R7");
    step(1, 1, 0, 0, 1, 'h013E, 'h013E, 4, 4, "R7");
    // R2: no update holds
    step(0, 0, 1, 1, 0, 'h013E, 'h013E, 8, 8, "R2");
    // R10: carry out wraps in circular mode
    mod_start_i = 16'h0010;
    mod_end_i   = 16'h0020;
    step(1, 1, 1, 1, 0, 'hFFFE, 'hFFFE, 4, 4, "R10");
    step(1, 1, 1, 0, 1, 'hFFFE, 'hFFFE, 4, 4, "R10");

    for (int i = 0; i < 4000; i++) begin
      int xp, yp;
      if (i % 500 == 0) begin
        mod_start_i = 16'(($urandom % 'h200) + 'h80);
        mod_end_i   = 16'(int'(mod_start_i) + ($urandom % 'h80));
      end
      xp = ($urandom % 8 == 0) ? int'($urandom % 65536)
                               : int'(mod_start_i) + int'($urandom % 'h90) - 8;
      yp = ($urandom % 8 == 0) ? int'($urandom % 65536)
                               : int'(mod_start_i) + int'($urandom % 'h90) - 8;
      step(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 10) < 7,
           $urandom % 2 == 1, $urandom % 2 == 1,
           xp & MASK, yp & MASK,
           ($urandom % 16 == 0) ? int'($urandom % 65536) : int'($urandom % 9),
           ($urandom % 16 == 0) ? int'($urandom % 65536) : int'($urandom % 9), "");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule